// File: doc/BRIEF.md
# Wait-State Stretched Bus Master and Slave

This block joins a clocked bus master to a memory-like slave over a bus where a transfer normally takes one clock period. Local logic hands the master a request: a command, an address and, for writes, data. The master drives these onto the internal bus for one bus cycle. A slave that can answer within that period keeps its WAIT line low, and the transfer ends at the next clock edge. A slave that needs longer raises WAIT during the first cycle. The master then adds whole idle clock periods until WAIT falls. It completes the transfer with the same edge timing as an unstretched one.

The slave decodes the top address bits into an address region. Each region has its own access latency, set by a parameter. The latency is the number of extra clock periods the slave holds WAIT. The master can optionally count WAIT samples. When WAIT stays high for a set number of samples, the master abandons the transfer and reports an error to the local logic.

Top module: `wait_stretch_bus`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, rsp_err is 0, bus_busy is 0 and bus_wait is 0.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. From that edge until the response, bus_busy is 1 and req_ready is 0.
- R3: The latency region is req_addr[7:6]. With default parameters, regions 0, 1, 2 and 3 have latencies of 0, 1, 3 and 9 extra clock periods. In region 0, bus_wait never rises, and rsp_valid is high in the cycle right after the first edge that follows acceptance.
- R4: For a region with latency L below the timeout, bus_wait is high for exactly L cycles. rsp_valid is high in the cycle after the (L+1)-th rising edge that follows acceptance.
- R5: Address, command and write data on the bus stay constant for every cycle of a stretched transfer.
- R6: A completed write stores req_wdata at word req_addr[3:0]. The storage is shared by all regions, so the word can be read back through any region.
- R7: A completed read returns the stored word on rsp_rdata with rsp_err 0. A write response, or any errored response, carries rsp_rdata 0.
- R8: rsp_valid is a one-cycle pulse. rsp_err is never 1 while rsp_valid is 0.
- R9: The default timeout is 8. If WAIT is sampled high for 8 successive edges, the transfer is abandoned at the 8th of those edges. rsp_valid and rsp_err are then high in the next cycle. An abandoned write leaves storage unchanged.
- R10: bus_wait is 1 only while a bus transfer is in progress.
- R11: A transfer whose WAIT falls is always completed without error on the next cycle's response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local logic presents a request |
| req_ready | output | 1 | Master is idle and takes a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Request address (region in top bits, word in low bits) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a timeout abort |
| rsp_rdata | output | 16 | Read data for a completed read, else 0 |
| bus_busy | output | 1 | A bus transfer is in progress |
| bus_wait | output | 1 | Slave WAIT line as seen by the master |

## Verification
On every cycle, the assertions check that the bus fields hold still while WAIT stretches a transfer. They also check that WAIT appears only inside a transfer, that responses are one-cycle pulses, and that an acceptance always starts a transfer. They check that a low WAIT during a transfer always ends it without error, and that WAIT never runs longer than the timeout. Only the bench scenarios can show the cycle count for each region's latency, the data that writes store and reads return across aliased regions, and that an abandoned write leaves storage untouched.

// File: rtl/wsb_pkg.sv
// Package: shared types for the wait-stretched bus.
// Assumes: nothing beyond IEEE 1800-2017.
package wsb_pkg;

    // Master sequencer state.
    typedef enum logic {
        MST_IDLE = 1'b0,
        MST_BUSY = 1'b1
    } mst_state_t;

endpackage

// File: rtl/wsb_lat_decode.sv
// Module: wsb_lat_decode
// What it does: maps an address region to that region's access latency.
// Assumes: REGION_LAT packs one LAT_W-bit field per region, region 0 in the low bits.
module wsb_lat_decode #(
    parameter int NUM_REGIONS = 4,
    parameter int LAT_W       = 8,
    parameter logic [NUM_REGIONS*LAT_W-1:0] REGION_LAT = {8'd9, 8'd3, 8'd1, 8'd0},
    localparam int RB = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [RB-1:0]    region,
    output logic [LAT_W-1:0] latency
);

    logic [LAT_W-1:0] lat_tab [NUM_REGIONS];

    // Unpack the latency parameter into one entry per region.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_tab
        assign lat_tab[g] = REGION_LAT[g*LAT_W +: LAT_W];
    end

    // Select the entry for the decoded region; out-of-range regions get 0.
    always_comb begin
        latency = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (region == RB'(i)) latency = lat_tab[i];
        end
    end

endmodule

// File: rtl/wsb_slave.sv
// Module: wsb_slave
// What it does: word storage slave that holds WAIT for a latency chosen by
//   address region, then completes the transfer: it stores write data, or
//   drives read data during the final bus cycle.
// Assumes: the master holds the bus fields stable while bus_active is high,
//   and it ends the transfer at the first edge where WAIT is low.
module wsb_slave #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int DEPTH       = 16,
    parameter int NUM_REGIONS = 4,
    parameter int LAT_W       = 8,
    parameter logic [NUM_REGIONS*LAT_W-1:0] REGION_LAT = {8'd9, 8'd3, 8'd1, 8'd0},
    localparam int IW = $clog2(DEPTH),
    localparam int RB = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_active,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_wait,
    output logic [DW-1:0] bus_rdata
);

    logic [DW-1:0]    mem [DEPTH];
    logic [LAT_W-1:0] elapsed;
    logic [LAT_W-1:0] latency;
    logic [IW-1:0]    word_idx;
    logic [RB-1:0]    region;

    assign word_idx = bus_addr[IW-1:0];
    assign region   = bus_addr[AW-1 -: RB];

    wsb_lat_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .LAT_W       (LAT_W),
        .REGION_LAT  (REGION_LAT)
    ) u_lat (
        .region  (region),
        .latency (latency)
    );

    // WAIT is high from the first cycle of a transfer until enough cycles have elapsed.
    assign bus_wait  = bus_active && (elapsed < latency);
    // Read data is driven during the final cycle of a transfer.
    assign bus_rdata = mem[word_idx];

    // Count the stretched cycles of the current transfer; clear between transfers.
    always_ff @(posedge clk) begin
        if (!rst_n)                    elapsed <= '0;
        else if (bus_active && bus_wait) elapsed <= elapsed + 1'b1;
        else                           elapsed <= '0;
    end

    // Store write data at the edge that completes a write transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (bus_active && !bus_wait && bus_write) begin
            mem[word_idx] <= bus_wdata;
        end
    end

endmodule

// File: rtl/wsb_master.sv
// Module: wsb_master
// What it does: takes one request from the local logic and runs it as a bus
//   transfer. It samples WAIT at every edge of the transfer, ends on the first
//   low sample and returns a response pulse. An optional counter abandons the
//   transfer after TIMEOUT high samples.
// Assumes: the slave answers WAIT combinationally within the first bus cycle.
//   TIMEOUT = 0 disables the abort.
module wsb_master
    import wsb_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int TIMEOUT = 8,
    localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT + 1) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_active,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_wait,
    input  logic [DW-1:0] bus_rdata
);

    mst_state_t state;
    logic       accept;
    logic       finish_ok;
    logic       give_up;

    assign req_ready  = (state == MST_IDLE);
    assign bus_active = (state == MST_BUSY);
    assign accept     = req_valid && req_ready;
    assign finish_ok  = bus_active && !bus_wait;

    // Timeout variant picked by the parameter.
    if (TIMEOUT > 0) begin : g_timeout
        logic [TW-1:0] wait_seen;

        assign give_up = bus_active && bus_wait && (wait_seen == TW'(TIMEOUT - 1));

        // Count WAIT-high samples within the current transfer.
        always_ff @(posedge clk) begin
            if (!rst_n || !bus_active)  wait_seen <= '0;
            else if (bus_wait)          wait_seen <= wait_seen + 1'b1;
        end
    end else begin : g_no_timeout
        assign give_up = 1'b0;
    end

    // Sequencer: idle until a request is taken, busy until completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                      state <= MST_IDLE;
        else if (accept)                 state <= MST_BUSY;
        else if (finish_ok || give_up)   state <= MST_IDLE;
    end

    // Capture the bus fields at acceptance and hold them for the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_write <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (accept) begin
            bus_write <= req_write;
            bus_addr  <= req_addr;
            bus_wdata <= req_wdata;
        end
    end

    // Produce a one-cycle response at completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= finish_ok || give_up;
            rsp_err   <= give_up;
            rsp_rdata <= (finish_ok && !bus_write) ? bus_rdata : '0;
        end
    end

endmodule

// File: rtl/wait_stretch_bus.sv
// Module: wait_stretch_bus
// What it does: top level. A master sequencer and a wait-state slave share an
//   internal single-clock bus. Local logic talks to it through a
//   request/response pair.
// Assumes: one clock domain, with a synchronous active-low reset.
module wait_stretch_bus #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int DEPTH       = 16,
    parameter int NUM_REGIONS = 4,
    parameter int LAT_W       = 8,
    parameter logic [NUM_REGIONS*LAT_W-1:0] REGION_LAT = {8'd9, 8'd3, 8'd1, 8'd0},
    parameter int TIMEOUT     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_busy,
    output logic          bus_wait
);

    logic          bus_active;
    logic          bus_write;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    assign bus_busy = bus_active;

    wsb_master #(
        .AW      (AW),
        .DW      (DW),
        .TIMEOUT (TIMEOUT)
    ) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .bus_active (bus_active),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wait   (bus_wait),
        .bus_rdata  (bus_rdata)
    );

    wsb_slave #(
        .AW          (AW),
        .DW          (DW),
        .DEPTH       (DEPTH),
        .NUM_REGIONS (NUM_REGIONS),
        .LAT_W       (LAT_W),
        .REGION_LAT  (REGION_LAT)
    ) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_active (bus_active),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wait   (bus_wait),
        .bus_rdata  (bus_rdata)
    );

endmodule

// File: rtl/wait_stretch_bus_checker.sv
// Module: wait_stretch_bus_checker
// What it does: cycle-by-cycle protocol properties for wait_stretch_bus.
// Assumes: it is bound into wait_stretch_bus and sees the internal bus fields.
module wait_stretch_bus_checker #(
    parameter int AW      = 8,
    parameter int DW      = 16,
    parameter int TIMEOUT = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic          bus_busy,
    input logic          bus_wait,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata
);

    // R2: an accepted request starts a bus transfer at the next cycle.
    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_busy);

    // R5: bus fields are held while WAIT stretches the transfer.
    assert_fields_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && bus_wait) |=> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    // R8: response is a single-cycle pulse.
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: error flag only accompanies a response.
    assert_err_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R10: WAIT only inside a transfer.
    assert_wait_in_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> bus_busy);

    // R11: a low WAIT sample ends the transfer with a clean response.
    assert_done_on_low_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !bus_wait) |=> (rsp_valid && !rsp_err && !bus_busy));

    // R9: WAIT never outlasts the timeout window, counted here rather than unrolled.
    if (TIMEOUT > 0) begin : g_to_chk
        int unsigned run_len;

        // Track the run of consecutive WAIT-high cycles.
        always_ff @(posedge clk) begin
            if (!rst_n)                     run_len <= 0;
            else if (bus_busy && bus_wait)  run_len <= run_len + 1;
            else                            run_len <= 0;
        end

        assert_wait_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
            run_len <= TIMEOUT);
    end

endmodule

bind wait_stretch_bus wait_stretch_bus_checker #(
    .AW      (AW),
    .DW      (DW),
    .TIMEOUT (TIMEOUT)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .bus_busy  (bus_busy),
    .bus_wait  (bus_wait),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/wait_stretch_bus_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases and seeded random transfers against a reference model.
module wait_stretch_bus_tb;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_err, bus_busy, bus_wait;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] ref_mem [16];
    bit done = 0;

    always #2.5 clk = ~clk;

    wait_stretch_bus u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .bus_busy  (bus_busy),
        .bus_wait  (bus_wait)
    );

    // Region latency from the requirement (R3).
    function automatic int region_lat(input logic [AW-1:0] a);
        case (a[7:6])
            2'd0: return 0;
            2'd1: return 1;
            2'd2: return 3;
            default: return 9;
        endcase
    endfunction

    function automatic bit aborts(input logic [AW-1:0] a);
        return region_lat(a) >= TO;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one transfer from a negedge and check timing, wait length and response.
    task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n;
        int waits;
        int exp_n;
        int exp_w;
        logic [DW-1:0] exp_rd;
        bit ab;
        while (!req_ready) @(negedge clk);
        ab     = aborts(a);
        exp_n  = ab ? TO + 1 : region_lat(a) + 2;
        exp_w  = ab ? TO : region_lat(a);
        exp_rd = (!wr && !ab) ? ref_mem[a[3:0]] : '0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        n = 1; waits = 0;
        req_valid = 1'b0; req_wdata = ~d;
        check(req_ready == 1'b0 && bus_busy == 1'b1, "R2 busy after accept", {req_ready, bus_busy}, 1);
        while (!rsp_valid && n < 40) begin
            if (bus_wait) waits++;
            @(negedge clk);
            n++;
        end
        if (ab) check(n == exp_n, "R9 abort timing", n, exp_n);
        else    check(n == exp_n, "R4 response timing", n, exp_n);
        check(waits == exp_w, ab ? "R9 wait samples" : "R3 R4 wait cycles", waits, exp_w);
        check(rsp_err == ab, "R9 error flag", rsp_err, ab);
        check(rsp_rdata == exp_rd, "R7 response data", rsp_rdata, exp_rd);
        if (wr && !ab) ref_mem[a[3:0]] = d;
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R8 single pulse", {rsp_valid, rsp_err}, 0);
        check(bus_wait == 1'b0, "R10 wait idle", bus_wait, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < 16; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R1 no response", {rsp_valid, rsp_err}, 0);
        check(bus_busy == 1'b0 && bus_wait == 1'b0, "R1 bus idle", {bus_busy, bus_wait}, 0);

        // R3 zero-latency write and read
        run_txn(1'b1, 8'h05, 16'hA5A5);
        run_txn(1'b0, 8'h05, 16'h0000);
        // R4 one-wait and three-wait regions; R6 aliasing across regions
        run_txn(1'b1, 8'h47, 16'h1234);
        run_txn(1'b0, 8'h87, 16'h0000);
        run_txn(1'b0, 8'h07, 16'h0000);
        // R9 abort on write leaves storage unchanged, seen through region 0
        run_txn(1'b1, 8'hC7, 16'hDEAD);
        run_txn(1'b0, 8'h07, 16'h0000);
        run_txn(1'b0, 8'hC5, 16'h0000);
        // R6 last word index
        run_txn(1'b1, 8'h8F, 16'hFFFF);
        run_txn(1'b0, 8'h0F, 16'h0000);

        // Seeded random mix
        seed = 32'd12345;
        void'($urandom(seed));
        for (int k = 0; k < 80; k++) begin
            logic [AW-1:0] ra;
            logic [DW-1:0] rd;
            bit rw;
            ra = AW'($urandom);
            rd = DW'($urandom);
            rw = 1'($urandom);
            run_txn(rw, ra, rd);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule